// File: doc/BRIEF.md
# Strided Multi-Register Word Load Sequencer

This block carries out one contiguous load of 32-bit words that fills either two or four vector registers. The destination registers are not adjacent but spaced at a fixed stride. A start pulse supplies everything the block needs: a signed 4-bit offset, a group bit, a 3-bit register field, a pair/quad select, a 64-bit base address and an already-expanded per-element predicate mask. The block first computes the start address. The offset is scaled by the whole footprint of the register group, which is register count × elements per vector × 4 bytes. It then walks the elements one at a time.

Active elements produce a read request on a valid/ready request channel. A read response then returns on a valid/ready response channel. An inactive element is written as zero and costs no memory traffic, but the address still advances past it. Once every element is held, each assembled vector is written out on a one-cycle write port as index plus full data. A done pulse follows the last write.

On back-pressure: a raised request holds its valid and address unchanged until the memory side takes it with ready. Only one read is outstanding at a time. The block raises response ready only while it waits for that single response. Each channel transfers on a clock edge where both its valid and ready are high.

Top module: `strided_vload_seq`

## Requirements
- R1: The first element address is base + sign-extended offset × (registers × VLEN/32 × 4), computed modulo 2^64. Registers is 2 in pair mode and 4 in quad mode. The offset is a two's-complement 4-bit value.
- R2: Elements are visited register by register, element 0 upward within each register. The address rises by exactly 4 per element across register boundaries, whether or not the element is active.
- R3: An element whose mask bit is 0 issues no read request and appears as 32 zero bits in its destination vector. The mask bit for register r, element e is bit r × (VLEN/32) + e.
- R4: Pair mode (quad_mode=0) writes two registers. The first index is grp_bit×16 + reg_field[2:0], and the stride is 8.
- R5: Quad mode (quad_mode=1) writes four registers. The first index is grp_bit×16 + reg_field[1:0], and the stride is 4. All indices wrap modulo 32.
- R6: Register writes occur in increasing r order, one per cycle, with wr_en high for one cycle each. Element e of a vector sits at data bits [32e+31:32e]. The data is the read response for an active element.
- R7: busy is high from the cycle after an accepted start through the cycle of the final write. done is high for exactly the one cycle after the final write, while busy is low.
- R8: A start seen while busy is ignored. The running operation's requests and writes are unchanged.
- R9: A raised read request keeps its valid high and its address stable until accepted. rd_rsp_ready is high only while no request is pending.
- R10: In pair mode the mask bits at and above 2 × (VLEN/32) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| offset_imm | input | 4 | Signed offset in units of the group footprint |
| grp_bit | input | 1 | High bit of the first destination index |
| reg_field | input | 3 | Low bits of the first destination index |
| quad_mode | input | 1 | 0: two registers, 1: four registers |
| base_addr | input | 64 | Base byte address |
| pred_mask | input | 4*VLEN/32 | Per-element active mask |
| busy | output | 1 | Operation in progress |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | 64 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block accepts read data |
| rd_rsp_data | input | 32 | Read data word |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | VLEN | Destination vector data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets negative offsets that wrap the address below zero, and a base near the top of the address space that wraps past it. A design that scaled the offset by one vector, or that dropped the sign, would request the wrong first address. Masks with holes at register boundaries, an all-zero mask and a pair-mode mask with only upper bits set expose two faults: a block that reads inactive elements, or that fails to advance the address past them. Either one shows up as an unexpected request or a shifted address. Back-pressure on both channels, together with a start pulse in mid-operation, shows whether a block drops a held request or restarts on a second start. Either fault breaks the expected request and write sequence.

// File: rtl/svl_pkg.sv
package svl_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_REQ,
    ST_RSP,
    ST_WRITE
  } svl_state_e;
endpackage

// File: rtl/svl_addr_calc.sv
module svl_addr_calc #(
  parameter int ADDR_W   = 64,
  parameter int LG_ELEMS = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [3:0]        imm,
  input  logic              quad,
  output logic [ADDR_W-1:0] start_addr
);
  // footprint = regs * elems * 4 bytes, always a power of two
  localparam int SH_PAIR = LG_ELEMS + 3;
  localparam int SH_QUAD = LG_ELEMS + 4;

  logic [ADDR_W-1:0] sext;
  logic [ADDR_W-1:0] scaled;

  always_comb begin
    sext       = {{(ADDR_W-4){imm[3]}}, imm};
    scaled     = quad ? (sext << SH_QUAD) : (sext << SH_PAIR);
    start_addr = base + scaled;
  end
endmodule

// File: rtl/svl_dest_calc.sv
module svl_dest_calc
  import svl_pkg::*;
(
  input  logic             grp,
  input  logic [2:0]       field,
  input  logic             quad,
  input  logic [1:0]       reg_num,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] first;
  logic [IDX_W-1:0] step;

  always_comb begin
    if (quad) begin
      first = {grp, 2'b00, field[1:0]};
      step  = {1'b0, reg_num, 2'b00};
    end else begin
      first = {grp, 1'b0, field};
      step  = {reg_num[0], 4'b0000} >> 1;
    end
    idx = first + step;
  end
endmodule

// File: rtl/svl_elem_store.sv
module svl_elem_store
  import svl_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int ELEMS = VLEN / WORD_W,
  parameter int MAXE  = 4 * ELEMS,
  parameter int SEL_W = $clog2(MAXE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        rsel,
  output logic [VLEN-1:0]   rdata
);
  logic [WORD_W-1:0] word_q [MAXE];

  for (genvar k = 0; k < MAXE; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[k] <= '0;
      end else if (we && (wsel == SEL_W'(k))) begin
        word_q[k] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int e = 0; e < ELEMS; e++) begin
      rdata[e*WORD_W +: WORD_W] = word_q[int'(rsel) * ELEMS + e];
    end
  end
endmodule

// File: rtl/strided_vload_seq.sv
module strided_vload_seq
  import svl_pkg::*;
#(
  parameter int VLEN   = 128,
  parameter int ADDR_W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [3:0]               offset_imm,
  input  logic                     grp_bit,
  input  logic [2:0]               reg_field,
  input  logic                     quad_mode,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [4*VLEN/WORD_W-1:0] pred_mask,
  output logic                     busy,
  output logic                     rd_req_valid,
  input  logic                     rd_req_ready,
  output logic [ADDR_W-1:0]        rd_req_addr,
  input  logic                     rd_rsp_valid,
  output logic                     rd_rsp_ready,
  input  logic [WORD_W-1:0]        rd_rsp_data,
  output logic                     wr_en,
  output logic [IDX_W-1:0]         wr_idx,
  output logic [VLEN-1:0]          wr_data,
  output logic                     done
);
  localparam int ELEMS    = VLEN / WORD_W;
  localparam int LG_ELEMS = $clog2(ELEMS);
  localparam int MAXE     = 4 * ELEMS;
  localparam int SEL_W    = $clog2(MAXE);
  localparam logic [SEL_W-1:0] LAST_QUAD = SEL_W'(MAXE - 1);
  localparam logic [SEL_W-1:0] LAST_PAIR = SEL_W'(2 * ELEMS - 1);

  svl_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SEL_W-1:0]  eidx_q;
  logic [1:0]        ridx_q;
  logic              quad_q;
  logic              grp_q;
  logic [2:0]        field_q;
  logic [MAXE-1:0]   mask_q;
  logic              done_q;

  logic [ADDR_W-1:0] start_addr;
  logic              last_elem;
  logic              last_reg;
  logic              store_we;
  logic [WORD_W-1:0] store_data;
  logic              advance;

  svl_addr_calc #(.ADDR_W(ADDR_W), .LG_ELEMS(LG_ELEMS)) u_addr (
    .base       (base_addr),
    .imm        (offset_imm),
    .quad       (quad_mode),
    .start_addr (start_addr)
  );

  svl_dest_calc u_dest (
    .grp     (grp_q),
    .field   (field_q),
    .quad    (quad_q),
    .reg_num (ridx_q),
    .idx     (wr_idx)
  );

  svl_elem_store #(.VLEN(VLEN)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .wsel  (eidx_q),
    .wdata (store_data),
    .rsel  (ridx_q),
    .rdata (wr_data)
  );

  always_comb begin
    last_elem  = eidx_q == (quad_q ? LAST_QUAD : LAST_PAIR);
    last_reg   = ridx_q == (quad_q ? 2'd3 : 2'd1);
    store_we   = 1'b0;
    store_data = '0;
    advance    = 1'b0;
    case (state_q)
      ST_PICK: if (!mask_q[eidx_q]) begin
        store_we = 1'b1;
        advance  = 1'b1;
      end
      ST_RSP: if (rd_rsp_valid) begin
        store_we   = 1'b1;
        store_data = rd_rsp_data;
        advance    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      eidx_q  <= '0;
      ridx_q  <= '0;
      quad_q  <= 1'b0;
      grp_q   <= 1'b0;
      field_q <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          addr_q  <= start_addr;
          eidx_q  <= '0;
          ridx_q  <= '0;
          quad_q  <= quad_mode;
          grp_q   <= grp_bit;
          field_q <= reg_field;
          mask_q  <= pred_mask;
          state_q <= ST_PICK;
        end
        ST_PICK: if (mask_q[eidx_q]) state_q <= ST_REQ;
        ST_REQ:  if (rd_req_ready) state_q <= ST_RSP;
        ST_WRITE: begin
          if (last_reg) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            ridx_q <= ridx_q + 2'd1;
          end
        end
        default: ;
      endcase
      if (advance) begin
        addr_q <= addr_q + ADDR_W'(4);
        eidx_q <= eidx_q + SEL_W'(1);
        state_q <= last_elem ? ST_WRITE : ST_PICK;
      end
    end
  end

  assign busy         = state_q != ST_IDLE;
  assign rd_req_valid = state_q == ST_REQ;
  assign rd_req_addr  = addr_q;
  assign rd_rsp_ready = state_q == ST_RSP;
  assign wr_en        = state_q == ST_WRITE;
  assign done         = done_q;
endmodule

// File: rtl/svl_checker.sv
module svl_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_ready
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid);

  p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(wr_en));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wr_en |=> busy);

  p_traffic_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || wr_en || rd_rsp_ready) |-> busy);
endmodule

bind strided_vload_seq svl_checker #(.ADDR_W(ADDR_W)) u_svl_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .wr_en        (wr_en),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_ready (rd_rsp_ready)
);

// File: tb/strided_vload_seq_bench.sv
module strided_vload_seq_bench;
  localparam int VLEN  = 128;
  localparam int ELEMS = VLEN / 32;
  localparam int MAXE  = 4 * ELEMS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [3:0]      offset_imm = '0;
  logic            grp_bit = 1'b0;
  logic [2:0]      reg_field = '0;
  logic            quad_mode = 1'b0;
  logic [63:0]     base_addr = '0;
  logic [MAXE-1:0] pred_mask = '0;
  logic            busy, rd_req_valid, rd_rsp_ready, wr_en, done;
  logic            rd_req_ready = 1'b1;
  logic [63:0]     rd_req_addr;
  logic            rd_rsp_valid = 1'b0;
  logic [31:0]     rd_rsp_data = '0;
  logic [4:0]      wr_idx;
  logic [VLEN-1:0] wr_data;

  always #2.5 clk = ~clk;

  strided_vload_seq #(.VLEN(VLEN)) u_strided_vload_seq (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int bp = 0;
  logic [63:0]     aq[$];
  logic [4:0]      wiq[$];
  logic [VLEN-1:0] wdq[$];
  bit  exp_busy = 0;
  bit  exp_done = 0;
  bit  hs_req = 0, hs_rsp = 0;
  logic [63:0] cap_addr;
  bit  pend = 0;
  int  dly = 0;
  logic [63:0] paddr;

  function automatic logic [31:0] memval(logic [63:0] a);
    return a[31:0] ^ a[63:32] ^ 32'h3C5A_96E1;
  endfunction

  task automatic chk(bit ok, string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: builds the expected traffic on accepted start
  task automatic build_model();
    int nreg, stride, first, simm;
    logic [63:0] a;
    logic [VLEN-1:0] v;
    nreg   = quad_mode ? 4 : 2;
    stride = quad_mode ? 4 : 8;
    first  = grp_bit * 16 + (quad_mode ? reg_field % 4 : reg_field);
    simm   = offset_imm > 7 ? int'(offset_imm) - 16 : int'(offset_imm);
    a = base_addr + 64'(simm * nreg * ELEMS * 4);
    for (int r = 0; r < nreg; r++) begin
      v = '0;
      for (int e = 0; e < ELEMS; e++) begin
        if (pred_mask[r*ELEMS+e]) begin
          aq.push_back(a);
          v[e*32 +: 32] = memval(a);
        end
        a = a + 64'd4;
      end
      wiq.push_back(5'((first + r * stride) % 32));
      wdq.push_back(v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit nb, nd;
      logic [63:0] ea;
      nb = exp_busy;
      nd = 0;
      chk(busy == exp_busy, "R7 busy", VLEN'(busy), VLEN'(exp_busy));
      chk(done == exp_done, "R7 done", VLEN'(done), VLEN'(exp_done));
      chk(!(rd_req_valid && !exp_busy), "R8 idle request", VLEN'(rd_req_valid), '0);
      hs_req = rd_req_valid && rd_req_ready;
      hs_rsp = rd_rsp_valid && rd_rsp_ready;
      if (hs_req) begin
        cap_addr = rd_req_addr;
        if (aq.size() == 0) begin
          chk(0, "R3 unexpected request", VLEN'(rd_req_addr), '0);
        end else begin
          ea = aq.pop_front();
          chk(rd_req_addr == ea, "R1 R2 address", VLEN'(rd_req_addr), VLEN'(ea));
        end
      end
      if (wr_en) begin
        if (wiq.size() == 0) begin
          chk(0, "R6 unexpected write", VLEN'(wr_idx), '0);
        end else begin
          logic [4:0] ei;
          logic [VLEN-1:0] ed;
          ei = wiq.pop_front();
          ed = wdq.pop_front();
          chk(wr_idx == ei, "R4 R5 index", VLEN'(wr_idx), VLEN'(ei));
          chk(wr_data == ed, "R6 R3 data", wr_data, ed);
          if (wiq.size() == 0) begin
            nb = 0;
            nd = 1;
            chk(aq.size() == 0, "R3 missing request", VLEN'(aq.size()), '0);
          end
        end
      end
      if (start && !exp_busy) begin
        build_model();
        nb = 1;
      end
      exp_busy = nb;
      exp_done = nd;
    end
  end

  // memory side with optional back-pressure
  always @(posedge clk) begin
    #1;
    cyc++;
    if (hs_rsp) rd_rsp_valid = 1'b0;
    if (hs_req) begin
      pend  = 1;
      paddr = cap_addr;
      dly   = bp ? cyc % 3 : 0;
    end
    hs_req = 0;
    hs_rsp = 0;
    if (pend && !rd_rsp_valid) begin
      if (dly == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = memval(paddr);
        pend = 0;
      end else begin
        dly--;
      end
    end
    rd_req_ready = bp ? (cyc % 3 != 0) : 1'b1;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_op(logic [3:0] imm, logic g, logic [2:0] f, logic q,
                        logic [63:0] b, logic [MAXE-1:0] m, bit poke);
    @(posedge clk); #1;
    offset_imm = imm; grp_bit = g; reg_field = f; quad_mode = q;
    base_addr = b; pred_mask = m; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // R8: second start mid-operation with different fields
      repeat (3) @(posedge clk);
      #1;
      offset_imm = 4'h5; grp_bit = ~g; reg_field = 3'd0; quad_mode = ~q;
      base_addr = 64'hDEAD_0000; pred_mask = '1; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (!(done && wiq.size() == 0)) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_en && !rd_req_valid && !done, "R7 reset state",
        VLEN'({busy, wr_en, rd_req_valid, done}), '0);
    // R4 pair, all active
    run_op(4'h0, 1'b0, 3'd3, 1'b0, 64'h1000, '1, 0);
    // R5 quad, negative offset, holes in mask
    run_op(4'hF, 1'b1, 3'd2, 1'b1, 64'h2000, 16'hA5C3, 0);
    // R10 pair with only upper mask bits set: no reads, all zero
    run_op(4'h7, 1'b0, 3'd5, 1'b0, 64'h3000, 16'hFF00, 0);
    bp = 1;
    // R1 wrap below zero, quad, back-pressure
    run_op(4'h8, 1'b1, 3'd7, 1'b1, 64'h10, '1, 0);
    // R1 wrap past top, pair, R8 start while busy
    run_op(4'h1, 1'b1, 3'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0081, 1);
    // R3 quad with empty mask
    run_op(4'h2, 1'b0, 3'd4, 1'b1, 64'h4000, '0, 0);
    // R2 quad, mask crossing register boundaries
    run_op(4'h3, 1'b0, 3'd1, 1'b1, 64'h5004, 16'h1F8E, 1);
    bp = 0;
    run_op(4'hC, 1'b1, 3'd0, 1'b0, 64'h8000_0000, 16'h00F0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule